// File: doc/BRIEF.md
# Multi-State Trigger Sequencer

This block decides when a logic analyzer capture should stop. One sample word arrives on every clock. The block runs a small programmable state machine with four states and two clauses in each state. A clause can test the sample against a masked value or an inclusive unsigned range. It can also test the arm input from a companion module, or test whether the internal event counter has reached a programmed limit. The first clause that matches picks the action: move to another state, fire the final trigger, or pulse an arm output to a companion module. A clause may also step or clear the event counter. Every matching clause that carries a store flag raises the storage-qualify output, so only selected samples are kept.

Software loads the clause setup through a plain write port. The port holds a control word, two operand words for each clause, and one counter limit. Evaluation is registered: a match seen on a clock edge shows up on the outputs after that same edge. Once the trigger fires, the sequencer halts until it is restarted.

Top module: `trig_seq`

## Requirements
- R1: After reset the state is 0, the block is not halted, and trig_o, arm_o, store_o and count_o are 0. Every clause is disabled and the counter limit is 0.
- R2: The value condition (kind code 0) matches when ((sample ^ A) & B) == 0, where A is the value word and B is the mask word of the clause.
- R3: The range condition (kind code 1) matches when A <= sample <= B, compared unsigned with both bounds included.
- R4: The external condition (kind code 2) matches while ext_arm_i is high.
- R5: The counter condition (kind code 3) matches when count >= limit. The winning clause's clear flag (ctrl bit 7) sets the count to 0, and clear beats increment. Its increment flag (ctrl bit 6) adds one, and the count saturates at 0xFFFF.
- R6: When both enabled clauses of the current state match, clause 0 alone selects the action and the counter update.
- R7: Action code 0 (go) loads the target state from ctrl bits 5:4. Action code 3 (hold) leaves the state unchanged.
- R8: Action code 1 (trigger) raises trig_o for exactly one cycle and sets halted_o. While halted, the state and count stay frozen and arm_o, store_o and trig_o stay low until a restart.
- R9: Action code 2 (arm) raises arm_o for one cycle and loads the target state. trig_o and arm_o are never high together.
- R10: store_o goes high one cycle after any enabled clause of the current state matches with its store flag (ctrl bit 9) set, whichever clause wins, and only while not halted.
- R11: restart_i, sampled on an edge, puts the block in state 0, not halted, with the count at 0 and the pulse and store outputs low. It takes priority over evaluation.
- R12: The block is registered. A match on the inputs at edge N changes state_o, count_o and the pulse outputs right after edge N, using the configuration held before that edge.
- R13: Configuration write map. Address bit 5 set writes the counter limit. Otherwise bits 4:3 give the state, bit 2 the clause, and bits 1:0 the field: 0 is ctrl, 1 is A, 2 is B, 3 is ignored. In ctrl, bits 1:0 are the kind, bits 3:2 the action, and bit 8 the clause enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Return to state 0 and clear the halt |
| sample_i | input | 16 | Sample word, one per clock |
| ext_arm_i | input | 1 | Arm signal from a companion module |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 6 | Configuration address |
| cfg_wdata_i | input | 16 | Configuration write data |
| trig_o | output | 1 | Final trigger pulse |
| arm_o | output | 1 | Arm pulse to a companion module |
| store_o | output | 1 | Storage qualify |
| halted_o | output | 1 | Trigger has fired, waiting for restart |
| state_o | output | 2 | Current sequencer state |
| count_o | output | 16 | Event counter value |

## Verification
Masked samples that differ only in don't-care bits are set against samples that differ in a cared-for bit, which separates the mask from a plain compare. Range samples one step outside and exactly on each bound show whether the bounds are inclusive and compared unsigned. A state whose clauses both match shows the clause priority. A counter that runs for more than 65,536 cycles shows the saturation, and a stretch of random samples, arm levels, restarts and clause setups checks that all the condition kinds and actions work together.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  localparam int NUM_STATES  = 4;
  localparam int NUM_CLAUSES = 2;
  localparam int ST_W        = $clog2(NUM_STATES);
  localparam int CL_W        = $clog2(NUM_CLAUSES);
  localparam int FLD_W       = 2;
  localparam int CFG_AW      = 1 + ST_W + CL_W + FLD_W;

  typedef enum logic [1:0] {K_VALUE = 2'd0, K_RANGE = 2'd1, K_EXT = 2'd2, K_COUNT = 2'd3} cond_kind_e;
  typedef enum logic [1:0] {A_GOTO = 2'd0, A_TRIG = 2'd1, A_ARM = 2'd2, A_HOLD = 2'd3} act_e;

  typedef struct packed {
    logic            store;
    logic            en;
    logic            cnt_clr;
    logic            cnt_inc;
    logic [ST_W-1:0] tgt;
    act_e            act;
    cond_kind_e      kind;
  } clause_ctrl_t;

  localparam int CTRL_W = $bits(clause_ctrl_t);
endpackage

// File: rtl/trig_seq_cfg.sv
module trig_seq_cfg
  import trig_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int CFGW = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [CFG_AW-1:0]             addr_i,
  input  logic [CFGW-1:0]               wdata_i,
  input  logic [ST_W-1:0]               sel_i,
  output clause_ctrl_t [NUM_CLAUSES-1:0] ctrl_o,
  output logic [NUM_CLAUSES-1:0][DW-1:0] a_o,
  output logic [NUM_CLAUSES-1:0][DW-1:0] b_o,
  output logic [CW-1:0]                 limit_o
);
  clause_ctrl_t      ctrl_q [NUM_STATES][NUM_CLAUSES];
  logic [DW-1:0]     a_q    [NUM_STATES][NUM_CLAUSES];
  logic [DW-1:0]     b_q    [NUM_STATES][NUM_CLAUSES];
  logic [CW-1:0]     lim_q;

  logic [ST_W-1:0]   w_st;
  logic [CL_W-1:0]   w_cl;
  logic [FLD_W-1:0]  w_fld;

  assign w_fld = addr_i[FLD_W-1:0];
  assign w_cl  = addr_i[FLD_W +: CL_W];
  assign w_st  = addr_i[FLD_W+CL_W +: ST_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_STATES; s++) begin
        for (int c = 0; c < NUM_CLAUSES; c++) begin
          ctrl_q[s][c] <= '0;
          a_q[s][c]    <= '0;
          b_q[s][c]    <= '0;
        end
      end
      lim_q <= '0;
    end else if (we_i) begin
      if (addr_i[CFG_AW-1]) begin
        lim_q <= wdata_i[CW-1:0];
      end else begin
        case (w_fld)
          2'd0:    ctrl_q[w_st][w_cl] <= clause_ctrl_t'(wdata_i[CTRL_W-1:0]);
          2'd1:    a_q[w_st][w_cl]    <= wdata_i[DW-1:0];
          2'd2:    b_q[w_st][w_cl]    <= wdata_i[DW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CLAUSES; c++) begin
      ctrl_o[c] = ctrl_q[sel_i][c];
      a_o[c]    = a_q[sel_i][c];
      b_o[c]    = b_q[sel_i][c];
    end
  end

  assign limit_o = lim_q;
endmodule

// File: rtl/trig_clause_eval.sv
module trig_clause_eval
  import trig_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          en_i,
  input  cond_kind_e    kind_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] sample_i,
  input  logic          ext_arm_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] limit_i,
  output logic          hit_o
);
  logic m;
  always_comb begin
    unique case (kind_i)
      K_VALUE: m = ((sample_i ^ a_i) & b_i) == '0;
      K_RANGE: m = (sample_i >= a_i) && (sample_i <= b_i);
      K_EXT:   m = ext_arm_i;
      K_COUNT: m = count_i >= limit_i;
      default: m = 1'b0;
    endcase
  end
  assign hit_o = en_i & m;
endmodule

// File: rtl/trig_seq_ctr.sv
module trig_seq_ctr #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] count_o
);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (inc_i && (cnt_q != '1))  cnt_q <= cnt_q + 1'b1;
  end
  assign count_o = cnt_q;
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16,
  localparam int CFGW = (DW > CW) ? DW : CW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [DW-1:0]     sample_i,
  input  logic              ext_arm_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFGW-1:0]   cfg_wdata_i,
  output logic              trig_o,
  output logic              arm_o,
  output logic              store_o,
  output logic              halted_o,
  output logic [ST_W-1:0]   state_o,
  output logic [CW-1:0]     count_o
);
  clause_ctrl_t [NUM_CLAUSES-1:0]  cur_ctrl;
  logic [NUM_CLAUSES-1:0][DW-1:0]  cur_a, cur_b;
  logic [CW-1:0]                   limit;
  logic [NUM_CLAUSES-1:0]          hit, store_sel;
  logic [ST_W-1:0]                 state_q;
  logic                            halted_q, trig_q, arm_q, store_q;
  logic                            win_v;
  logic [CL_W-1:0]                 win_idx;
  clause_ctrl_t                    win_ctrl;
  logic                            act;

  trig_seq_cfg #(.DW(DW), .CW(CW), .CFGW(CFGW)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .sel_i   (state_q),
    .ctrl_o  (cur_ctrl),
    .a_o     (cur_a),
    .b_o     (cur_b),
    .limit_o (limit)
  );

  for (genvar c = 0; c < NUM_CLAUSES; c++) begin : g_clause
    trig_clause_eval #(.DW(DW), .CW(CW)) u_eval (
      .en_i      (cur_ctrl[c].en),
      .kind_i    (cur_ctrl[c].kind),
      .a_i       (cur_a[c]),
      .b_i       (cur_b[c]),
      .sample_i  (sample_i),
      .ext_arm_i (ext_arm_i),
      .count_i   (count_o),
      .limit_i   (limit),
      .hit_o     (hit[c])
    );
    assign store_sel[c] = hit[c] & cur_ctrl[c].store;
  end

  // lowest index wins
  always_comb begin
    win_v   = 1'b0;
    win_idx = '0;
    for (int i = NUM_CLAUSES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win_v   = 1'b1;
        win_idx = CL_W'(i);
      end
    end
  end

  assign win_ctrl = cur_ctrl[win_idx];
  assign act      = win_v & ~halted_q & ~restart_i;

  trig_seq_ctr #(.CW(CW)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (restart_i | (act & win_ctrl.cnt_clr)),
    .inc_i   (act & win_ctrl.cnt_inc),
    .count_o (count_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= '0;
      halted_q <= 1'b0;
      trig_q   <= 1'b0;
      arm_q    <= 1'b0;
      store_q  <= 1'b0;
    end else if (restart_i) begin
      state_q  <= '0;
      halted_q <= 1'b0;
      trig_q   <= 1'b0;
      arm_q    <= 1'b0;
      store_q  <= 1'b0;
    end else begin
      trig_q  <= 1'b0;
      arm_q   <= 1'b0;
      store_q <= ~halted_q & (|store_sel);
      if (act) begin
        unique case (win_ctrl.act)
          A_GOTO: state_q <= win_ctrl.tgt;
          A_TRIG: begin
            trig_q   <= 1'b1;
            halted_q <= 1'b1;
          end
          A_ARM: begin
            arm_q   <= 1'b1;
            state_q <= win_ctrl.tgt;
          end
          default: ;
        endcase
      end
    end
  end

  assign trig_o   = trig_q;
  assign arm_o    = arm_q;
  assign store_o  = store_q;
  assign halted_o = halted_q;
  assign state_o  = state_q;
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk
  import trig_seq_pkg::*;
#(
  parameter int CW = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            restart_i,
  input logic            trig_o,
  input logic            arm_o,
  input logic            store_o,
  input logic            halted_o,
  input logic [ST_W-1:0] state_o,
  input logic [CW-1:0]   count_o
);
  assert_trig_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  assert_trig_halts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> halted_o);

  assert_halt_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !restart_i) |=> (halted_o && $stable(state_o) && $stable(count_o)
                                  && !arm_o && !store_o && !trig_o));

  assert_one_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trig_o && arm_o));

  assert_no_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '1 && !restart_i) |=> (count_o == '1 || count_o == '0));

  assert_count_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (count_o == $past(count_o) || count_o == '0
              || {1'b0, count_o} == {1'b0, $past(count_o)} + 1'b1));

  assert_restart_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (state_o == '0 && !halted_o && count_o == '0
                   && !trig_o && !arm_o && !store_o));
endmodule

bind trig_seq trig_seq_chk #(.CW(CW)) u_trig_seq_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .restart_i (restart_i),
  .trig_o    (trig_o),
  .arm_o     (arm_o),
  .store_o   (store_o),
  .halted_o  (halted_o),
  .state_o   (state_o),
  .count_o   (count_o)
);

// File: tb/tb_trig_seq.sv
module tb_trig_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        restart_i = 1'b0;
  logic [15:0] sample_i = '0;
  logic        ext_arm_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [5:0]  cfg_addr_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic        trig_o, arm_o, store_o, halted_o;
  logic [1:0]  state_o;
  logic [15:0] count_o;

  int tests = 0;
  int fails = 0;
  string cur_req = "R1";

  // reference model state
  int m_ctrl [4][2];
  int m_a [4][2];
  int m_b [4][2];
  int m_lim = 0;
  int m_st = 0, m_cnt = 0;
  bit m_halt = 0, m_trig = 0, m_arm = 0, m_store = 0;

  always #2 clk_i = ~clk_i;

  trig_seq dut (.*);

  function automatic int mk(int kind, int act, int tgt, bit inc, bit clr, bit en, bit st);
    return kind | (act << 2) | (tgt << 4) | (int'(inc) << 6) | (int'(clr) << 7)
           | (int'(en) << 8) | (int'(st) << 9);
  endfunction

  function automatic int ad(int s, int c, int f);
    return (s << 3) | (c << 2) | f;
  endfunction

  task automatic model_step();
    bit h [2];
    int win = -1;
    int smp = int'(sample_i);
    for (int c = 0; c < 2; c++) begin
      int k = m_ctrl[m_st][c];
      bit m = 0;
      case (k & 3)
        0: m = ((smp ^ m_a[m_st][c]) & m_b[m_st][c] & 16'hFFFF) == 0;
        1: m = (smp >= m_a[m_st][c]) && (smp <= m_b[m_st][c]);
        2: m = ext_arm_i;
        default: m = (m_cnt >= m_lim);
      endcase
      h[c] = m && ((k >> 8) & 1) == 1;
    end
    if (h[1]) win = 1;
    if (h[0]) win = 0;
    if (restart_i) begin
      m_st = 0; m_halt = 0; m_cnt = 0; m_trig = 0; m_arm = 0; m_store = 0;
    end else begin
      int k = (win >= 0) ? m_ctrl[m_st][win] : 0;
      m_store = !m_halt && ((h[0] && ((m_ctrl[m_st][0] >> 9) & 1) == 1)
                          || (h[1] && ((m_ctrl[m_st][1] >> 9) & 1) == 1));
      m_trig = 0; m_arm = 0;
      if (win >= 0 && !m_halt) begin
        if ((k >> 7) & 1) m_cnt = 0;
        else if (((k >> 6) & 1) && m_cnt != 16'hFFFF) m_cnt++;
        case ((k >> 2) & 3)
          0: m_st = (k >> 4) & 3;
          1: begin m_trig = 1; m_halt = 1; end
          2: begin m_arm = 1; m_st = (k >> 4) & 3; end
          default: ;
        endcase
      end
    end
    if (cfg_we_i) begin
      int a = int'(cfg_addr_i);
      int d = int'(cfg_wdata_i);
      if (a & 32) m_lim = d;
      else case (a & 3)
        0: m_ctrl[(a >> 3) & 3][(a >> 2) & 1] = d & 16'h3FF;
        1: m_a[(a >> 3) & 3][(a >> 2) & 1] = d;
        2: m_b[(a >> 3) & 3][(a >> 2) & 1] = d;
        default: ;
      endcase
    end
  endtask

  task automatic compare();
    tests++;
    if (trig_o !== m_trig || arm_o !== m_arm || store_o !== m_store || halted_o !== m_halt
        || int'(state_o) != m_st || int'(count_o) != m_cnt) begin
      fails++;
      $display("FAIL %s: got trig=%b arm=%b store=%b halt=%b st=%0d cnt=%0d exp trig=%b arm=%b store=%b halt=%b st=%0d cnt=%0d",
               cur_req, trig_o, arm_o, store_o, halted_o, state_o, count_o,
               m_trig, m_arm, m_store, m_halt, m_st, m_cnt);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    compare();
  endtask

  task automatic drive(int smp, bit arm);
    sample_i = 16'(smp);
    ext_arm_i = arm;
    cyc();
  endtask

  task automatic wr(int a, int d);
    cfg_we_i = 1'b1; cfg_addr_i = 6'(a); cfg_wdata_i = 16'(d);
    cyc();
    cfg_we_i = 1'b0;
  endtask

  task automatic restart();
    restart_i = 1'b1;
    cyc();
    restart_i = 1'b0;
  endtask

  bit done = 0;
  initial begin
    #(4ns * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++) begin m_ctrl[s][c] = 0; m_a[s][c] = 0; m_b[s][c] = 0; end
    repeat (3) @(negedge clk_i);
    cur_req = "R1";
    compare();
    rst_ni = 1'b1;
    drive(16'h1234, 1'b1);  // R1: all clauses disabled, nothing moves

    // R13 R2 R10: value match with mask, store flag
    cur_req = "R2";
    wr(ad(0, 0, 0), mk(0, 0, 1, 0, 0, 1, 1));
    wr(ad(0, 0, 1), 16'h1200);
    wr(ad(0, 0, 2), 16'hFF00);
    wr(ad(0, 0, 3), 16'h0000);  // R13: field 3 ignored
    drive(16'h1300, 0);
    drive(16'h0200, 0);
    cur_req = "R10";
    drive(16'h12AB, 0);
    drive(16'h0000, 0);

    // R3: inclusive unsigned range in state 1
    cur_req = "R3";
    wr(ad(1, 0, 0), mk(1, 0, 2, 0, 0, 1, 0));
    wr(ad(1, 0, 1), 16'h0010);
    wr(ad(1, 0, 2), 16'h0020);
    drive(16'h000F, 0);
    drive(16'h0021, 0);
    drive(16'hFFFF, 0);
    drive(16'h0020, 0);
    restart();
    drive(16'h1200, 0);
    drive(16'h0010, 0);

    // R4 R9 R7: external arm -> arm pulse, always-hold increments
    cur_req = "R4";
    wr(ad(2, 0, 0), mk(2, 2, 3, 0, 0, 1, 0));
    wr(ad(2, 1, 0), mk(0, 3, 0, 1, 0, 1, 0));
    wr(ad(2, 1, 2), 16'h0000);
    wr(32, 12);
    drive(16'h5555, 0);
    drive(16'hAAAA, 0);
    cur_req = "R9";
    drive(16'h0000, 1);
    drive(16'h0000, 0);

    // R5 R6 R8: counter clause beats always-match clause, fires trigger
    cur_req = "R6";
    wr(ad(3, 0, 0), mk(3, 1, 0, 0, 0, 1, 0));
    wr(ad(3, 1, 0), mk(0, 3, 0, 1, 0, 1, 1));
    wr(ad(3, 1, 2), 16'h0000);
    cur_req = "R5";
    for (int i = 0; i < 14; i++) drive(i, 0);
    cur_req = "R8";
    for (int i = 0; i < 6; i++) drive(16'h1200, 1);

    // R11: restart clears halt
    cur_req = "R11";
    restart();
    drive(16'h0000, 0);

    // R6 R7: both clauses match, clause 0 target wins
    cur_req = "R6";
    wr(ad(0, 0, 0), mk(0, 0, 1, 0, 0, 1, 0));
    wr(ad(0, 0, 2), 16'h0000);
    wr(ad(0, 1, 0), mk(0, 0, 2, 0, 1, 1, 1));
    restart();
    cur_req = "R7";
    drive(16'hBEEF, 0);
    drive(16'hBEEF, 0);

    // R5: saturation at 0xFFFF, then clear
    cur_req = "R5";
    wr(ad(0, 0, 0), mk(0, 3, 0, 1, 0, 1, 0));
    wr(ad(0, 1, 0), 0);
    restart();
    for (int i = 0; i < 65540; i++) drive(i, 0);
    wr(ad(0, 0, 0), mk(0, 3, 0, 1, 1, 1, 0));
    drive(0, 0);

    // R12: random mixed activity
    cur_req = "R12";
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++) begin
        wr(ad(s, c, 0), int'($urandom_range(0, 1023)) | 256);
        wr(ad(s, c, 1), int'($urandom_range(0, 15)));
        wr(ad(s, c, 2), int'($urandom_range(0, 15)));
      end
    wr(32, 5);
    for (int i = 0; i < 3000; i++) begin
      restart_i = ($urandom_range(0, 40) == 0);
      if ($urandom_range(0, 60) == 0) begin
        int ri = int'($urandom_range(0, 1));
        cfg_we_i = 1'b1;
        cfg_addr_i = 6'($urandom_range(0, 31));
        cfg_wdata_i = 16'($urandom_range(0, 1023) | (ri << 8));
      end
      drive(int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
      cfg_we_i = 1'b0;
    end
    restart_i = 1'b0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule